// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block collects interrupt events from two engines and reports them to a host. The first engine is a bus-side DMA engine with one byte of event bits. The second is a device-side protocol engine with two bytes of event bits. The host sees the events through a byte-wide register port and through one active-low interrupt line. A global status register shows one summary bit for each engine, a software flag, and a flag that marks the clear window as open. Each event byte has a detail register and an enable mask register.

Reading a detail register returns the bits that are currently visible. The same read also schedules a clear of exactly those bits. The clear takes effect a fixed number of clocks later, 12 by default. Each bit has a second stage. An event that lands on a bit that is already visible, or on a bit that is being cleared in that same cycle, is stored in the second stage and is not lost. When the visible bit clears, the stored event moves forward and drives the interrupt line again, so the service routine runs once more.

Top module: `isc_ctrl`

## Requirements
- R1: After synchronous reset, all visible and stored bits are zero and every mask byte is 0xFF. The global status reads 0x00, irq_n is high and host_rdata is 0x00.
- R2: The global status register is at address 0. Bit 0 is the DMA summary, bit 1 is the protocol summary, bit 2 is the software flag and bit 3 is the clear-window flag. Bits 7:4 read as zero.
- R3: An event bit that is sampled high on a clock edge is visible after that edge. The DMA summary is the OR of the enabled visible DMA bits. The protocol summary is the OR of the enabled visible bits in both protocol bytes.
- R4: An event on a bit that is already visible is stored in the second stage. When the visible bit is cleared, the stored bit takes its place on the same edge.
- R5: The detail registers are at address 1 (DMA), address 2 (protocol bits 7:0) and address 3 (protocol bits 15:8). A read of one of them returns its visible byte and opens a clear window, so status bit 3 becomes 1. The bits that the read returned are cleared on the 12th rising edge after the edge that sampled the read. No other bits are cleared.
- R6: A detail read that is sampled while the clear window is open still returns data. It schedules no clear.
- R7: The mask registers are at addresses 4, 5 and 6, in the same order as the detail registers. They can be read and written. A bit whose mask is 0 is still recorded and can still be read, but it drives neither irq_n nor a summary bit.
- R8: An event on a bit in the same cycle as that bit's clear is kept. It is visible one edge after the clear.
- R9: A high sw_evt sets the software flag. Writing 1 to status bit 2 clears it, and writing 0 leaves it unchanged. While the flag is set, irq_n is low.
- R10: irq_n is low exactly when an enabled visible bit or the software flag is set. It returns high as soon as the last of these clears.
- R11: host_rdata is registered and is valid one edge after the read is sampled. Address 7 reads as 0x00. Writes to the detail or status addresses change no detail bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register address |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| dma_evt | input | 8 | DMA engine event bits, each sampled on the clock edge |
| proto_evt | input | 16 | Protocol engine event bits, each sampled on the clock edge |
| sw_evt | input | 1 | Sets the software flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench first reads a detail register on the last edge before the clear lands, to confirm it still holds the old value. It then reads again one edge later to confirm the stored event has moved forward. A design with the wrong latency would report a cleared value early, or a stale value late. The bench reads a second detail register while the window is open and checks that the bits are still there afterwards. A design that accepted that read as a clear would silently lose a protocol event. An event is pulsed on the exact edge where its bit clears. A design that let the clear win would leave irq_n high and the bit empty. Masked bits, the write-one-to-clear flag and the unmapped address are also checked, since each of these has a visible failure at the ports.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int BYTE_W     = 8;
    localparam int UNIT_IDX_W = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    // One event bit: visible stage and stored (second) stage
    typedef struct packed {
        logic vis;
        logic stk;
    } slot_t;

    // Global status layout, LSB last
    typedef struct packed {
        logic [3:0] spare;
        logic       busy;
        logic       swf;
        logic       psum;
        logic       dsum;
    } gstat_t;

    // Clear command issued when the latency window closes
    typedef struct packed {
        logic                  fire;
        logic [UNIT_IDX_W-1:0] unit;
        byte_t                 mask;
    } clr_cmd_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_GSTAT,
        REG_DETAIL,
        REG_MASK
    } reg_kind_e;

    // Next state of one bit given its event and clear inputs
    function automatic slot_t slot_next(slot_t cur, logic evt, logic clr);
        slot_t n;
        if (clr) begin
            n.vis = cur.stk;
            n.stk = evt;
        end else if (cur.vis) begin
            n.vis = 1'b1;
            n.stk = cur.stk | evt;
        end else begin
            n.vis = cur.stk | evt;
            n.stk = cur.stk & evt;
        end
        return n;
    endfunction

    // Address map: 0 status, 1..nunit detail, nunit+1..2*nunit masks
    function automatic reg_kind_e decode_kind(int a, int nunit);
        if (a == 0)
            return REG_GSTAT;
        else if (a <= nunit)
            return REG_DETAIL;
        else if (a <= 2 * nunit)
            return REG_MASK;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/isc_stack_bank.sv
module isc_stack_bank
    import isc_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] vis
);

    for (genvar g = 0; g < W; g++) begin : g_slot
        slot_t st;
        always_ff @(posedge clk) begin
            if (rst)
                st <= '0;
            else
                st <= slot_next(st, evt[g], clr && clr_mask[g]);
        end
        assign vis[g] = st.vis;
    end

endmodule

// File: rtl/isc_clear_seq.sv
module isc_clear_seq
    import isc_pkg::*;
#(
    parameter int LAT = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic [UNIT_IDX_W-1:0] req_unit,
    input  byte_t                 req_mask,
    output logic                  busy,
    output clr_cmd_t              cmd
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]         cnt;
    logic [UNIT_IDX_W-1:0] unit_q;
    byte_t                 mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            unit_q <= '0;
            mask_q <= '0;
        end else if (cnt == '0) begin
            if (req) begin
                cnt    <= CW'(LAT);
                unit_q <= req_unit;
                mask_q <= req_mask;
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy     = (cnt != '0);
    assign cmd.fire = (cnt == CW'(1));
    assign cmd.unit = unit_q;
    assign cmd.mask = mask_q;

endmodule

// File: rtl/isc_host_regs.sv
module isc_host_regs
    import isc_pkg::*;
#(
    parameter int NUNIT = 3,
    parameter int AW    = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [AW-1:0]               addr,
    input  logic                        rd,
    input  logic                        wr,
    input  byte_t                       wdata,
    input  logic [NUNIT-1:0][BYTE_W-1:0] vis,
    input  logic                        busy,
    input  logic                        dsum,
    input  logic                        psum,
    input  logic                        sw_evt,
    output byte_t                       rdata,
    output logic [NUNIT-1:0][BYTE_W-1:0] mask,
    output logic                        swflag,
    output logic                        clr_req,
    output logic [UNIT_IDX_W-1:0]       clr_unit,
    output byte_t                       clr_mask
);

    reg_kind_e             kind;
    logic [UNIT_IDX_W-1:0] det_idx;
    logic [UNIT_IDX_W-1:0] msk_idx;
    byte_t                 rd_val;
    gstat_t                gs;
    gstat_t                wgs;

    always_comb begin
        kind    = decode_kind(int'(addr), NUNIT);
        det_idx = UNIT_IDX_W'(int'(addr) - 1);
        msk_idx = UNIT_IDX_W'(int'(addr) - 1 - NUNIT);
        wgs     = gstat_t'(wdata);
    end

    always_comb begin
        gs       = '0;
        gs.dsum  = dsum;
        gs.psum  = psum;
        gs.swf   = swflag;
        gs.busy  = busy;
        rd_val   = '0;
        case (kind)
            REG_GSTAT:  rd_val = byte_t'(gs);
            REG_DETAIL: begin
                for (int i = 0; i < NUNIT; i++)
                    if (det_idx == UNIT_IDX_W'(i)) rd_val = vis[i];
            end
            REG_MASK: begin
                for (int i = 0; i < NUNIT; i++)
                    if (msk_idx == UNIT_IDX_W'(i)) rd_val = mask[i];
            end
            default:    rd_val = '0;
        endcase
    end

    assign clr_req  = rd && (kind == REG_DETAIL) && !busy;
    assign clr_unit = det_idx;
    assign clr_mask = rd_val;

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= rd_val;
    end

    for (genvar i = 0; i < NUNIT; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask[i] <= '1;
            else if (wr && kind == REG_MASK && msk_idx == UNIT_IDX_W'(i))
                mask[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            swflag <= 1'b0;
        else if (sw_evt)
            swflag <= 1'b1;
        else if (wr && kind == REG_GSTAT && wgs.swf)
            swflag <= 1'b0;
    end

endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
    import isc_pkg::*;
#(
    parameter  int PROTO_BYTES = 2,
    parameter  int CLR_LAT     = 12,
    localparam int NUNIT       = PROTO_BYTES + 1,
    localparam int AW          = $clog2(2 * NUNIT + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [AW-1:0]                   host_addr,
    input  logic                            host_rd,
    input  logic                            host_wr,
    input  logic [BYTE_W-1:0]               host_wdata,
    output logic [BYTE_W-1:0]               host_rdata,
    input  logic [BYTE_W-1:0]               dma_evt,
    input  logic [BYTE_W*PROTO_BYTES-1:0]   proto_evt,
    input  logic                            sw_evt,
    output logic                            irq_n
);

    logic [NUNIT-1:0][BYTE_W-1:0] evt_all;
    logic [NUNIT-1:0][BYTE_W-1:0] vis_all;
    logic [NUNIT-1:0][BYTE_W-1:0] mask_all;
    logic [NUNIT-1:0]             unit_clr;

    clr_cmd_t              cmd;
    logic                  clr_busy;
    logic                  clr_req;
    logic [UNIT_IDX_W-1:0] clr_unit;
    byte_t                 clr_mask;
    logic                  sw_flag;
    logic                  dsum;
    logic                  psum;

    assign evt_all[0] = dma_evt;
    for (genvar p = 0; p < PROTO_BYTES; p++) begin : g_evt
        assign evt_all[p+1] = proto_evt[p*BYTE_W +: BYTE_W];
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        assign unit_clr[u] = cmd.fire && (cmd.unit == UNIT_IDX_W'(u));
        isc_stack_bank #(.W(BYTE_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_all[u]),
            .clr      (unit_clr[u]),
            .clr_mask (cmd.mask),
            .vis      (vis_all[u])
        );
    end

    isc_clear_seq #(.LAT(CLR_LAT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (clr_req),
        .req_unit (clr_unit),
        .req_mask (clr_mask),
        .busy     (clr_busy),
        .cmd      (cmd)
    );

    isc_host_regs #(.NUNIT(NUNIT), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (host_addr),
        .rd       (host_rd),
        .wr       (host_wr),
        .wdata    (host_wdata),
        .vis      (vis_all),
        .busy     (clr_busy),
        .dsum     (dsum),
        .psum     (psum),
        .sw_evt   (sw_evt),
        .rdata    (host_rdata),
        .mask     (mask_all),
        .swflag   (sw_flag),
        .clr_req  (clr_req),
        .clr_unit (clr_unit),
        .clr_mask (clr_mask)
    );

    always_comb begin
        dsum = |(vis_all[0] & mask_all[0]);
        psum = 1'b0;
        for (int p = 1; p < NUNIT; p++)
            psum = psum | (|(vis_all[p] & mask_all[p]));
    end

    assign irq_n = ~(dsum | psum | sw_flag);

endmodule

// File: rtl/isc_ctrl_chk.sv
module isc_ctrl_chk #(
    parameter int LAT = 12,
    parameter int AW  = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] host_addr,
    input logic          host_wr,
    input logic [7:0]    host_wdata,
    input logic [7:0]    dma_evt,
    input logic          sw_evt,
    input logic          irq_n,
    input logic          busy,
    input logic          swflag,
    input logic [7:0]    dma_vis,
    input logic          dma_clr
);

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 16'd1;
        else
            run_len <= '0;
    end

    // R5: the clear window stays open for exactly LAT cycles
    a_r5_window_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == 16'(LAT)));

    // R4: visible bits never drop without a clear of their unit
    a_r4_vis_hold: assert property (@(posedge clk) disable iff (rst)
        !dma_clr |=> ((dma_vis & $past(dma_vis)) == $past(dma_vis)));

    // R3: a sampled event is visible on the next cycle when no clear lands
    a_r3_evt_seen: assert property (@(posedge clk) disable iff (rst)
        !dma_clr |=> ((dma_vis & $past(dma_evt)) == $past(dma_evt)));

    // R9: a set request raises the software flag
    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        sw_evt |=> swflag);

    // R9: writing one to the flag bit clears it
    a_r9_flag_clr: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == '0 && host_wdata[2] && !sw_evt) |=> !swflag);

    // R10: a set software flag holds the interrupt line low
    a_r10_flag_irq: assert property (@(posedge clk) disable iff (rst)
        swflag |-> !irq_n);

endmodule

bind isc_ctrl isc_ctrl_chk #(.LAT(CLR_LAT), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .dma_evt    (dma_evt),
    .sw_evt     (sw_evt),
    .irq_n      (irq_n),
    .busy       (clr_busy),
    .swflag     (sw_flag),
    .dma_vis    (vis_all[0]),
    .dma_clr    (unit_clr[0])
);

// File: tb/isc_ctrl_test.sv
module isc_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  dma_evt = '0;
    logic [15:0] proto_evt = '0;
    logic        sw_evt = 1'b0;
    logic        irq_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;

    isc_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dma_evt    (dma_evt),
        .proto_evt  (proto_evt),
        .sw_evt     (sw_evt),
        .irq_n      (irq_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Monitor: pops one expected item per sampled read
    always @(posedge clk) rd_seen <= host_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(host_rdata == e, t, host_rdata, e);
        end
    end

    // Driver tasks: called at a negedge, return at the next negedge
    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        host_addr = a;
        host_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse_dma(input logic [7:0] v);
        dma_evt = v;
        @(negedge clk);
        dma_evt = '0;
    endtask

    task automatic pulse_proto(input logic [15:0] v);
        proto_evt = v;
        @(negedge clk);
        proto_evt = '0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        check(irq_n == e, tag, irq_n, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        irq_chk(1'b1, "R1 irq_n after reset");
        rd_chk(3'd0, 8'h00, "R1 status after reset");
        rd_chk(3'd4, 8'hFF, "R1 mask reset value");
        rd_chk(3'd1, 8'h00, "R1 dma detail empty");
        idle(14);

        // R3 R2 R10 recording and summary
        pulse_dma(8'h05);
        irq_chk(1'b0, "R10 irq low on dma event");
        rd_chk(3'd0, 8'h01, "R2 dma summary bit");
        pulse_dma(8'h04);                                    // R4 stored behind bit 2
        rd_chk(3'd1, 8'h05, "R5 detail read returns visible"); // edge k
        rd_chk(3'd0, 8'h09, "R5 busy flag in window");         // edge k+1
        idle(10);
        rd_chk(3'd1, 8'h05, "R5 not cleared before 12th edge"); // edge k+12
        rd_chk(3'd1, 8'h04, "R4 stored bit moved forward");     // edge k+13
        irq_chk(1'b0, "R4 irq asserted by stored bit");
        idle(13);
        irq_chk(1'b1, "R10 irq high after last clear");
        rd_chk(3'd1, 8'h00, "R5 detail cleared");
        idle(14);

        // R6 read during window schedules no clear
        pulse_proto(16'h0010);
        rd_chk(3'd0, 8'h02, "R3 protocol summary bit");
        rd_chk(3'd1, 8'h00, "R6 open window via dma read");
        rd_chk(3'd2, 8'h10, "R6 read inside window");
        idle(14);
        rd_chk(3'd2, 8'h10, "R6 bit survived window read");
        idle(14);
        rd_chk(3'd2, 8'h00, "R5 protocol byte cleared");
        idle(14);

        // R7 masking
        wr_reg(3'd4, 8'h00);
        rd_chk(3'd4, 8'h00, "R7 mask readback");
        pulse_dma(8'h80);
        irq_chk(1'b1, "R7 masked bit does not drive irq");
        rd_chk(3'd0, 8'h00, "R7 masked bit no summary");
        rd_chk(3'd1, 8'h80, "R7 masked bit recorded");
        idle(14);
        wr_reg(3'd4, 8'hFF);
        irq_chk(1'b1, "R7 cleared masked bit stays quiet");

        // R8 event on the clearing edge
        pulse_proto(16'h0100);
        rd_chk(3'd3, 8'h01, "R8 high byte detail");           // edge k
        idle(11);
        pulse_proto(16'h0100);                                // sampled at edge k+12
        @(negedge clk);
        irq_chk(1'b0, "R8 collided event raises irq");
        rd_chk(3'd3, 8'h01, "R8 collided event kept");
        idle(14);
        rd_chk(3'd3, 8'h00, "R8 byte empty after clear");
        idle(14);

        // R9 software flag
        sw_evt = 1'b1;
        @(negedge clk);
        sw_evt = 1'b0;
        irq_chk(1'b0, "R9 flag drives irq");
        rd_chk(3'd0, 8'h04, "R9 flag visible");
        wr_reg(3'd0, 8'h00);
        rd_chk(3'd0, 8'h04, "R9 write zero keeps flag");
        wr_reg(3'd0, 8'h04);
        irq_chk(1'b1, "R9 write one clears flag");
        rd_chk(3'd0, 8'h00, "R9 status clear");

        // R11 unmapped address and ignored detail write
        rd_chk(3'd7, 8'h00, "R11 unmapped reads zero");
        pulse_dma(8'h02);
        wr_reg(3'd1, 8'h00);
        rd_chk(3'd1, 8'h02, "R11 detail write ignored");
        idle(14);

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule